// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM with one shared data bus. Every input is registered on the rising clock edge. Read data comes out two enabled edges after its address cycle. Write data is taken from the bus two enabled edges after its address cycle. Because reads and writes have the same pipeline depth, the bus can carry any mix of reads and writes on consecutive cycles with no idle slot between them.

A load cycle starts an operation at an external address. A continue cycle repeats the previous operation at the next address of a four-beat burst. A held write buffer sits in front of the array, and a read of a word still in that buffer gets the pending bytes forwarded to it. The bidirectional bus is split into `dq_in`, `dq_out` and `dq_oe`.

The default depth is kept small (256 words of two 9-bit lanes) so that elaboration stays light. Setting `ADDR_W` to 18 gives the full 256K-word organisation. There is no valid/ready handshake, because the bus timing is fixed by the pipeline and the block never applies back-pressure. The clock-suspend input is the only way to stall it, and it stalls the whole block. `ADDR_W` must be at least 3.

Top module: `nwsram_top`

## Requirements
- R1: A read loaded at an enabled edge puts the word on `dq_out`, with `dq_oe` high, right after the second enabled edge that follows.
- R2: A load cycle with `rd_wrn` low starts a write. The word on `dq_in` is captured at the second enabled edge after the address cycle.
- R3: `lane_wr_n[i]` low during a write slot's address cycle updates bits `[i*LANE_W +: LANE_W]`. Lanes whose enable is high keep their old contents.
- R4: A load cycle with `csel0_n` high, `csel1` low or `csel2_n` high is a deselect. Its slot, and the continue cycles that follow it, perform no access and leave `dq_oe` low.
- R5: While `freeze` is high, every input is ignored and all pipeline state, the array and the outputs hold their values.
- R6: A continue cycle (`load_n` high) repeats the previous operation type. It keeps the upper address bits and advances a 2-bit beat count that wraps after four beats.
- R7: The beat address low bits are `(start+k) mod 4` when `order_ilv` is 0, and `start XOR k` when it is 1, where k is the beat number.
- R8: A read of a word whose write still sits in the pending buffer returns the pending data in the written lanes and the array data in the other lanes.
- R9: Reads and writes may alternate on every cycle, in any order, with no dead cycle, and each returns or stores the correct data.
- R10: `dq_oe` is high only for read slots. It is low for write and deselect slots.
- R11: Reset clears the pipeline and the pending buffer, so `dq_oe` is low afterwards. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline state |
| freeze | input | 1 | High suspends the clock: inputs are ignored and state holds |
| csel0_n | input | 1 | Chip select, active low |
| csel1 | input | 1 | Chip select, active high |
| csel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low loads a new address and operation; high continues the burst |
| rd_wrn | input | 1 | High selects a read, low a write (on load cycles) |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data to the bus |
| dq_oe | output | 1 | Bus output enable, high only in read slots |

## Verification
The hardest case to reach from the ports is a read that hits the pending write buffer. The write has to reach the capture stage exactly one enabled edge before the read at the same address, and only some of its lanes may be enabled, otherwise a fault in the merge stays hidden.

Two kinds of stimulus get there. Directed write-then-read pairs at one address use partial lane masks. A long randomized phase confined to eight addresses mixes loads, continue bursts in both orders, deselects and freeze cycles, so that writes pile up behind reads in many alignments. A behavioural model compares `dq_oe` and `dq_out` against the design on every clock.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Low two address bits for burst beat 'step' starting at 'start'.
  function automatic logic [1:0] burst_ofs(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic ilv);
    if (ilv) return start ^ step;
    return start + step;
  endfunction
endpackage

// File: rtl/nwsram_seq.sv
module nwsram_seq
  import nwsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              rd_wrn,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               cyc_op,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        step_q;
  logic [1:0]        step_nx;
  op_e               last_q;

  assign step_nx = step_q + 2'd1;

  always_comb begin
    if (!load_n) begin
      if (!sel_ok)     cyc_op = OP_IDLE;
      else if (rd_wrn) cyc_op = OP_RD;
      else             cyc_op = OP_WR;
      cyc_addr = addr;
    end else begin
      cyc_op   = last_q;
      cyc_addr = {base_q[ADDR_W-1:2], burst_ofs(base_q[1:0], step_nx, order_ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= 2'd0;
      last_q <= OP_IDLE;
    end else if (en) begin
      if (!load_n) begin
        base_q <= addr;
        step_q <= 2'd0;
        last_q <= cyc_op;
      end else begin
        step_q <= step_nx;
      end
    end
  end
endmodule

// File: rtl/nwsram_pipe.sv
module nwsram_pipe
  import nwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_mask,
  output op_e               head_op,
  output op_e               tail_op,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [LANES-1:0]  tail_mask
);
  op_e               op_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  mask_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        op_q[s]   <= OP_IDLE;
        addr_q[s] <= '0;
        mask_q[s] <= '0;
      end
    end else if (en) begin
      op_q[0]   <= in_op;
      addr_q[0] <= in_addr;
      mask_q[0] <= in_mask;
      for (int s = 1; s < STAGES; s++) begin
        op_q[s]   <= op_q[s-1];
        addr_q[s] <= addr_q[s-1];
        mask_q[s] <= mask_q[s-1];
      end
    end
  end

  assign head_op   = op_q[0];
  assign tail_op   = op_q[STAGES-1];
  assign tail_addr = addr_q[STAGES-1];
  assign tail_mask = mask_q[STAGES-1];
endmodule

// File: rtl/nwsram_store.sv
module nwsram_store
  import nwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  op_e                     slot_op,
  input  logic [ADDR_W-1:0]       slot_addr,
  input  logic [LANES-1:0]        slot_mask,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              wb_v;
  logic [ADDR_W-1:0] wb_a;
  logic [LANES-1:0]  wb_m;
  logic [DW-1:0]     wb_d;
  logic [DW-1:0]     arr_word;
  logic [DW-1:0]     rd_word;
  logic              wb_hit;

  assign arr_word = mem[slot_addr];
  assign wb_hit   = wb_v && (wb_a == slot_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_word[l*LANE_W +: LANE_W] = (wb_hit && wb_m[l]) ? wb_d[l*LANE_W +: LANE_W]
                                                             : arr_word[l*LANE_W +: LANE_W];
  end

  // Array: the pending word is committed at the next enabled edge.
  always_ff @(posedge clk) begin
    if (en && wb_v) begin
      for (int l = 0; l < LANES; l++) begin
        if (wb_m[l]) mem[wb_a][l*LANE_W +: LANE_W] <= wb_d[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_v <= 1'b0;
      wb_a <= '0;
      wb_m <= '0;
      wb_d <= '0;
      dout <= '0;
      oe   <= 1'b0;
    end else if (en) begin
      wb_v <= (slot_op == OP_WR);
      if (slot_op == OP_WR) begin
        wb_a <= slot_addr;
        wb_m <= slot_mask;
        wb_d <= din;
      end
      oe <= (slot_op == OP_RD);
      if (slot_op == OP_RD) dout <= rd_word;
    end
  end
endmodule

// File: rtl/nwsram_top.sv
module nwsram_top
  import nwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    freeze,
  input  logic                    csel0_n,
  input  logic                    csel1,
  input  logic                    csel2_n,
  input  logic                    load_n,
  input  logic                    rd_wrn,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    order_ilv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int PIPE_DEPTH = 2;

  logic              en;
  logic              sel_ok;
  op_e               cyc_op;
  logic [ADDR_W-1:0] cyc_addr;
  op_e               s1_op;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask;

  assign en     = !freeze;
  assign sel_ok = !csel0_n && csel1 && !csel2_n;

  nwsram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .load_n(load_n), .sel_ok(sel_ok),
    .rd_wrn(rd_wrn), .order_ilv(order_ilv), .addr(addr),
    .cyc_op(cyc_op), .cyc_addr(cyc_addr)
  );

  nwsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_op(cyc_op), .in_addr(cyc_addr), .in_mask(~lane_wr_n),
    .head_op(s1_op), .tail_op(s2_op), .tail_addr(s2_addr), .tail_mask(s2_mask)
  );

  nwsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .en(en),
    .slot_op(s2_op), .slot_addr(s2_addr), .slot_mask(s2_mask),
    .din(dq_in), .dout(dq_out), .oe(dq_oe)
  );
endmodule

// File: rtl/nwsram_chk.sv
module nwsram_chk
  import nwsram_pkg::*;
#(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          freeze,
  input logic          csel0_n,
  input logic          csel1,
  input logic          csel2_n,
  input logic          load_n,
  input logic          rd_wrn,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input op_e           s1_op,
  input op_e           s2_op
);
  a_r5_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(dq_out) && $stable(dq_oe)));

  a_r5_freeze_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(s1_op) && $stable(s2_op)));

  a_r10_oe_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && s2_op == OP_RD) |=> dq_oe);

  a_r10_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && s2_op != OP_RD) |=> !dq_oe);

  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !load_n && (csel0_n || !csel1 || csel2_n)) |=> (s1_op == OP_IDLE));

  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !load_n && !csel0_n && csel1 && !csel2_n && rd_wrn)
      ##1 !freeze ##1 !freeze |=> dq_oe);
endmodule

bind nwsram_top nwsram_chk #(.DW(LANES*LANE_W)) u_chk (.*);

// File: tb/nwsram_top_tb_top.sv
module nwsram_top_tb_top;
  localparam int AW    = 8;
  localparam int LN    = 2;
  localparam int LW    = 9;
  localparam int DW    = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          freeze = 1'b0;
  logic          csel0_n = 1'b1;
  logic          csel1 = 1'b0;
  logic          csel2_n = 1'b1;
  logic          load_n = 1'b1;
  logic          rd_wrn = 1'b1;
  logic [LN-1:0] lane_wr_n = '1;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc_cnt = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R11";
  int    desel_rot = 0;

  // Behavioural reference model state
  logic [DW-1:0] mm [DEPTH];
  int            m_base = 0;
  int            m_step = 0;
  int            m_last = 0;   // 0 idle, 1 read, 2 write
  int            p_op   [2] = '{0, 0};
  int            p_addr [2] = '{0, 0};
  logic [LN-1:0] p_mask [2] = '{'0, '0};
  logic          exp_oe = 1'b0;
  logic [DW-1:0] exp_dout = '0;

  always #10 clk = ~clk;   // 50 MHz

  nwsram_top #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .csel0_n(csel0_n), .csel1(csel1),
    .csel2_n(csel2_n), .load_n(load_n), .rd_wrn(rd_wrn), .lane_wr_n(lane_wr_n),
    .order_ilv(order_ilv), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_step = 0; m_last = 0;
      p_op[0] = 0; p_op[1] = 0;
      exp_oe = 1'b0; exp_dout = '0;
    end else if (!freeze) begin
      int op;
      int a;
      int lo;
      bit sel;
      sel = !csel0_n && csel1 && !csel2_n;
      if (!load_n) begin
        op = !sel ? 0 : (rd_wrn ? 1 : 2);
        a = int'(addr);
        m_base = a; m_step = 0; m_last = op;
      end else begin
        m_step = (m_step + 1) % 4;
        op = m_last;
        lo = order_ilv ? ((m_base % 4) ^ m_step) : ((m_base % 4 + m_step) % 4);
        a = m_base - (m_base % 4) + lo;
      end
      // slot two enabled edges old
      exp_oe = (p_op[1] == 1);
      if (p_op[1] == 1) exp_dout = mm[p_addr[1]];
      if (p_op[1] == 2) begin
        for (int l = 0; l < LN; l++)
          if (p_mask[1][l]) mm[p_addr[1]][l*LW +: LW] = dq_in[l*LW +: LW];
      end
      p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_mask[1] = p_mask[0];
      p_op[0] = op; p_addr[0] = a; p_mask[0] = ~lane_wr_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      n_chk++;
      if (dq_oe !== exp_oe) begin
        n_fail++;
        $display("FAIL %s/R10 cycle %0d: dq_oe=%0b expected %0b", cur_req, cyc_cnt, dq_oe, exp_oe);
      end else if (exp_oe && dq_out !== exp_dout) begin
        n_fail++;
        $display("FAIL %s/R1 cycle %0d: dq_out=%h expected %h", cur_req, cyc_cnt, dq_out, exp_dout);
      end
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic drive(input logic ld_n, input logic sel, input logic rw,
                       input logic [LN-1:0] ln_n, input int a, input logic ilv,
                       input logic frz, input string req);
    cur_req = req;
    load_n = ld_n; rd_wrn = rw; lane_wr_n = ln_n;
    addr = AW'(a); order_ilv = ilv; freeze = frz;
    dq_in = DW'($urandom);
    if (sel) begin
      csel0_n = 1'b0; csel1 = 1'b1; csel2_n = 1'b0;
    end else begin
      desel_rot = (desel_rot + 1) % 3;
      csel0_n = (desel_rot == 0); csel1 = (desel_rot != 1); csel2_n = (desel_rot == 2);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 1'b1, '1, 0, 1'b0, 1'b0, req);
  endtask

  task automatic burst(input logic rw, input int a, input logic ilv,
                       input logic [LN-1:0] ln_n, input string req);
    drive(1'b0, 1'b1, rw, ln_n, a, ilv, 1'b0, req);
    for (int k = 1; k < 4; k++) drive(1'b1, 1'b1, rw, ln_n, 0, ilv, 1'b0, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    n_chk++;
    if (dq_oe !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: dq_oe=%0b expected 0", dq_oe);
    end
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(2, "R11");

    // R2: preload whole array with linear write bursts
    for (int b = 0; b < DEPTH; b += 4) burst(1'b0, b, 1'b0, '0, "R2");
    idle(3, "R2");

    // R1: single reads, then R6/R7 read bursts from each start offset
    for (int a = 0; a < 8; a++) drive(1'b0, 1'b1, 1'b1, '1, a * 7, 1'b0, 1'b0, "R1");
    idle(3, "R1");
    for (int s = 0; s < 4; s++) burst(1'b1, 32 + s, 1'b0, '1, "R6");
    for (int s = 0; s < 4; s++) burst(1'b1, 64 + s, 1'b1, '1, "R7");
    idle(3, "R7");

    // R7: interleaved write burst from offset 3, read back linearly
    burst(1'b0, 99, 1'b1, '0, "R7");
    idle(3, "R7");
    burst(1'b1, 96, 1'b0, '1, "R7");
    idle(3, "R7");

    // R3: per-lane writes, then read back
    drive(1'b0, 1'b1, 1'b0, 2'b10, 10, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 2'b01, 11, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 2'b11, 12, 1'b0, 1'b0, "R3");
    drive(1'b0, 1'b1, 1'b0, 2'b00, 13, 1'b0, 1'b0, "R3");
    idle(3, "R3");
    for (int a = 10; a < 14; a++) drive(1'b0, 1'b1, 1'b1, '1, a, 1'b0, 1'b0, "R3");
    idle(3, "R3");

    // R8: write then immediate read of same word, partial lanes
    for (int a = 20; a < 24; a++) begin
      drive(1'b0, 1'b1, 1'b0, (a % 2) ? 2'b01 : 2'b10, a, 1'b0, 1'b0, "R8");
      drive(1'b0, 1'b1, 1'b1, '1, a, 1'b0, 1'b0, "R8");
    end
    drive(1'b0, 1'b1, 1'b0, 2'b00, 30, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b1, 1'b0, 2'b01, 30, 1'b0, 1'b0, "R8");
    drive(1'b0, 1'b1, 1'b1, '1, 30, 1'b0, 1'b0, "R8");
    idle(3, "R8");

    // R4: deselect load followed by continue cycles
    drive(1'b0, 1'b0, 1'b1, '1, 40, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 1'b1, '1, 0, 1'b0, 1'b0, "R4");
    drive(1'b1, 1'b1, 1'b0, '0, 0, 1'b0, 1'b0, "R4");
    drive(1'b0, 1'b0, 1'b0, '0, 41, 1'b0, 1'b0, "R4");
    idle(3, "R4");
    burst(1'b1, 40, 1'b0, '1, "R4");
    idle(3, "R4");

    // R5: freeze in the middle of reads and writes
    drive(1'b0, 1'b1, 1'b1, '1, 50, 1'b0, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, '0, 51, 1'b0, 1'b1, "R5");
    drive(1'b0, 1'b1, 1'b0, '0, 52, 1'b0, 1'b1, "R5");
    drive(1'b0, 1'b1, 1'b1, '1, 53, 1'b0, 1'b0, "R5");
    drive(1'b1, 1'b1, 1'b0, '0, 0, 1'b0, 1'b1, "R5");
    drive(1'b0, 1'b1, 1'b1, '1, 53, 1'b0, 1'b0, "R5");
    drive(1'b0, 1'b1, 1'b0, '0, 50, 1'b0, 1'b1, "R5");
    idle(4, "R5");
    for (int a = 50; a < 54; a++) drive(1'b0, 1'b1, 1'b1, '1, a, 1'b0, 1'b0, "R5");
    idle(3, "R5");

    // R9: alternating read/write every cycle, then a random mix on eight words
    for (int i = 0; i < 40; i++)
      drive(1'b0, 1'b1, i[0], 2'($urandom), 128 + (i % 4), 1'b0, 1'b0, "R9");
    for (int i = 0; i < 3000; i++)
      drive(($urandom % 3) == 0, ($urandom % 8) != 0, $urandom % 2, 2'($urandom),
            200 + int'($urandom % 8), $urandom % 2, ($urandom % 6) == 0, "R9");
    idle(4, "R9");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule